// File: doc/BRIEF.md
# Paged Address Translation Unit

This block turns a 16-bit logical word address into an extended physical page number and checks each access against the access rights stored for the page. A file of page registers is organised as sixteen banks, chosen by a 4-bit address-state value. Each bank holds one group of sixteen pages for operand space and one for instruction space. The top four address bits pick the page inside the group. The low twelve bits pass through as the word offset within a 4K-word page.

Each access carries a 4-bit key, taken from the processor-state value. The key is tested against the page's 4-bit lock. A per-page inhibit bit stops operand writes, or instruction fetches on instruction pages. The address-state and the key come either from input pins, while a DMA master owns the bus, or from an internal copy of the processor status word. Page registers can be rewritten through a register port that only works in privileged mode. The translated page and an active-low protect-error flag are registered. They become valid one clock after the address strobe rises.

Top module: `page_xlate_unit`

## Requirements
- R1: After reset, the entry for address-state S and page P in either space has lock F, inhibit 0, extension bits 0 and physical page {S,P}, which gives a linear 1M-word map.
- R2: One clock after a rising edge of `strobe_i`, `valid_o` is high and `offset_o` equals the low 12 bits of `laddr_i`. `valid_o` stays high until the strobe falls.
- R3: The entry is selected by the active address-state (bank), `opnd_i` (1 = operand group, 0 = instruction group) and `laddr_i[15:12]`. The write index `preg_idx_i` is {state[8:5], space[4], page[3:0]}.
- R4: Entry layout: [15:12] lock, [11] inhibit, [10:8] extension page bits, [7:0] page. With `ext_mode_i` high, `ppage_o` is bits [10:0]. With it low, `ppage_o[10:8]` is 0.
- R5: An access passes the key check when the key is 0, when the key equals the lock, or when the lock is F. Otherwise `prot_err_n_o` is low.
- R6: On an operand page with inhibit set, a write (`rd_i` = 0) drives `prot_err_n_o` low, and a read passes.
- R7: On an instruction page with inhibit set, every fetch drives `prot_err_n_o` low.
- R8: With `dma_ack_n_i` low, the address-state and key come from `pin_as_i` and `pin_ps_i`.
- R9: With `dma_ack_n_i` high, they come from a status copy that `stat_we_i` loads from `stat_as_i` and `stat_ps_i`. The copy resets to 0.
- R10: A page-register write happens on the next clock edge only when `preg_we_i` and `priv_i` are both high. Without `priv_i` the entry is left unchanged.
- R11: `prot_err_n_o` is low whenever `strobe_i` is low. While `valid_o` is high it is high only when the access passed R5 to R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strobe_i | input | 1 | Address strobe, active high |
| laddr_i | input | 16 | Logical word address |
| opnd_i | input | 1 | 1 operand access, 0 instruction access |
| rd_i | input | 1 | 1 read, 0 write |
| dma_ack_n_i | input | 1 | Low selects the pin address-state and key |
| pin_as_i | input | 4 | Address-state from the DMA master |
| pin_ps_i | input | 4 | Key from the DMA master |
| stat_we_i | input | 1 | Loads the status copy |
| stat_as_i | input | 4 | New address-state for the status copy |
| stat_ps_i | input | 4 | New key for the status copy |
| ext_mode_i | input | 1 | Enables the 11-bit physical page |
| priv_i | input | 1 | Privileged mode, gates register writes |
| preg_we_i | input | 1 | Page-register write request |
| preg_idx_i | input | 9 | Page-register index |
| preg_wdata_i | input | 16 | Page-register write data |
| ppage_o | output | 11 | Physical page number |
| offset_o | output | 12 | Word offset within the page |
| valid_o | output | 1 | Translation valid |
| prot_err_n_o | output | 1 | Protect error, active low |

## Verification
On every cycle, the assertions check the strobe-related timing. They check that the error flag is low while the strobe is idle, that `valid_o` follows one clock after a strobe rise and clears after the strobe falls, and that the offset is carried through unchanged. They also check that the extension bits are zero outside extended mode. Only the directed scenarios can show the contents of the translation. Those cover the identity map after reset, the bank, space and page selection, the lock/key outcomes, the inhibit bit in each space, the choice of key source, and writes dropped without privilege.

// File: rtl/pxu_pkg.sv
// Package: shared widths, page-register entry type and helper functions
// for the paged address translation unit.
// Assumes a 4-bit state, a 1-bit space select and a 4-bit page index.
package pxu_pkg;

    localparam int STATE_W = 4;
    localparam int PAGE_W  = 4;
    localparam int OFF_W   = 12;
    localparam int PPA_W   = 8;
    localparam int EXT_W   = 3;
    localparam int LOCK_W  = 4;
    localparam int IDX_W   = STATE_W + 1 + PAGE_W;
    localparam int NREG    = 1 << IDX_W;
    localparam int PPAGE_W = PPA_W + EXT_W;

    typedef struct packed {
        logic [LOCK_W-1:0] lock;
        logic              inhibit;
        logic [EXT_W-1:0]  ext;
        logic [PPA_W-1:0]  ppa;
    } preg_t;

    // Identity entry: physical page equals {state, page}, fully open.
    function automatic preg_t identity_entry(input logic [IDX_W-1:0] idx);
        preg_t e;
        e.lock    = '1;
        e.inhibit = 1'b0;
        e.ext     = '0;
        e.ppa     = PPA_W'({idx[IDX_W-1 -: STATE_W], idx[PAGE_W-1:0]});
        return e;
    endfunction

endpackage

// File: rtl/pxu_key_select.sv
// Key select: keeps the status-word copy of address-state and key, and
// picks either that copy or the DMA pins for the current access.
// Assumes the DMA acknowledge is active low.
module pxu_key_select
    import pxu_pkg::*;
#(
    parameter int SW = STATE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dma_ack_n_i,
    input  logic [SW-1:0] pin_as_i,
    input  logic [SW-1:0] pin_ps_i,
    input  logic          stat_we_i,
    input  logic [SW-1:0] stat_as_i,
    input  logic [SW-1:0] stat_ps_i,
    output logic [SW-1:0] as_o,
    output logic [SW-1:0] key_o
);
    logic [SW-1:0] copy_as_q;
    logic [SW-1:0] copy_ps_q;

    // Track the status-word copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            copy_as_q <= '0;
            copy_ps_q <= '0;
        end else if (stat_we_i) begin
            copy_as_q <= stat_as_i;
            copy_ps_q <= stat_ps_i;
        end
    end

    // Choose the source for the current access.
    always_comb begin
        if (!dma_ack_n_i) begin
            as_o  = pin_as_i;
            key_o = pin_ps_i;
        end else begin
            as_o  = copy_as_q;
            key_o = copy_ps_q;
        end
    end
endmodule

// File: rtl/pxu_page_file.sv
// Page file: banked page-register storage with one write port and one
// combinational read port. Reset loads the identity map.
// Assumes the write is already qualified by the privilege check.
module pxu_page_file
    import pxu_pkg::*;
#(
    parameter int IW = IDX_W,
    parameter int N  = NREG
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_i,
    input  logic [IW-1:0] widx_i,
    input  preg_t         wdata_i,
    input  logic [IW-1:0] ridx_i,
    output preg_t         rdata_o
);
    preg_t mem [N];

    // Hold the entries, reload the identity map on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                mem[i] <= identity_entry(IW'(i));
            end
        end else if (we_i) begin
            mem[widx_i] <= wdata_i;
        end
    end

    // Read the addressed entry.
    assign rdata_o = mem[ridx_i];
endmodule

// File: rtl/pxu_prot_check.sv
// Protection check: lock/key rule plus write or fetch inhibit.
// Purely combinational. Assumes operand select high means operand space.
module pxu_prot_check
    import pxu_pkg::*;
#(
    parameter int LW = LOCK_W
) (
    input  logic [LW-1:0] lock_i,
    input  logic [LW-1:0] key_i,
    input  logic          inhibit_i,
    input  logic          opnd_i,
    input  logic          rd_i,
    output logic          viol_o
);
    logic key_ok;
    logic inh_hit;

    // Decide whether the key opens the lock.
    always_comb begin
        key_ok = (key_i == '0) || (key_i == lock_i) || (lock_i == '1);
    end

    // Decide whether the inhibit bit blocks this access type.
    always_comb begin
        inh_hit = inhibit_i && (opnd_i ? !rd_i : 1'b1);
        viol_o  = !key_ok || inh_hit;
    end
endmodule

// File: rtl/page_xlate_unit.sv
// Paged address translation unit top: picks the page entry from the
// state, the space and the page index, checks access rights, and
// registers the result one clock after the address strobe rises.
// Assumes the address and control inputs are stable while the strobe is high.
module page_xlate_unit
    import pxu_pkg::*;
#(
    parameter int AW = STATE_W + OFF_W,
    parameter int PW = PPAGE_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 strobe_i,
    input  logic [AW-1:0]        laddr_i,
    input  logic                 opnd_i,
    input  logic                 rd_i,
    input  logic                 dma_ack_n_i,
    input  logic [STATE_W-1:0]   pin_as_i,
    input  logic [STATE_W-1:0]   pin_ps_i,
    input  logic                 stat_we_i,
    input  logic [STATE_W-1:0]   stat_as_i,
    input  logic [STATE_W-1:0]   stat_ps_i,
    input  logic                 ext_mode_i,
    input  logic                 priv_i,
    input  logic                 preg_we_i,
    input  logic [IDX_W-1:0]     preg_idx_i,
    input  logic [15:0]          preg_wdata_i,
    output logic [PW-1:0]        ppage_o,
    output logic [OFF_W-1:0]     offset_o,
    output logic                 valid_o,
    output logic                 prot_err_n_o
);
    logic [STATE_W-1:0] cur_as;
    logic [STATE_W-1:0] cur_key;
    logic [IDX_W-1:0]   ridx;
    preg_t              entry;
    logic               viol;
    logic               strobe_q;
    logic               rise;
    logic               viol_q;
    logic [PW-1:0]      ppage_d;

    pxu_key_select #(.SW(STATE_W)) u_keysel (
        .clk(clk), .rst_n(rst_n), .dma_ack_n_i(dma_ack_n_i),
        .pin_as_i(pin_as_i), .pin_ps_i(pin_ps_i),
        .stat_we_i(stat_we_i), .stat_as_i(stat_as_i), .stat_ps_i(stat_ps_i),
        .as_o(cur_as), .key_o(cur_key)
    );

    assign ridx = {cur_as, opnd_i, laddr_i[AW-1 -: PAGE_W]};

    pxu_page_file #(.IW(IDX_W), .N(NREG)) u_file (
        .clk(clk), .rst_n(rst_n),
        .we_i(preg_we_i && priv_i), .widx_i(preg_idx_i),
        .wdata_i(preg_t'(preg_wdata_i)),
        .ridx_i(ridx), .rdata_o(entry)
    );

    pxu_prot_check #(.LW(LOCK_W)) u_prot (
        .lock_i(entry.lock), .key_i(cur_key), .inhibit_i(entry.inhibit),
        .opnd_i(opnd_i), .rd_i(rd_i), .viol_o(viol)
    );

    // Form the physical page, using the extension bits only in extended mode.
    always_comb begin
        ppage_d = ext_mode_i ? PW'({entry.ext, entry.ppa}) : PW'(entry.ppa);
    end

    assign rise = strobe_i && !strobe_q;

    // Detect the strobe edge and capture the translation on it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strobe_q <= 1'b0;
            valid_o  <= 1'b0;
            viol_q   <= 1'b1;
            ppage_o  <= '0;
            offset_o <= '0;
        end else begin
            strobe_q <= strobe_i;
            valid_o  <= strobe_i && (rise || valid_o);
            if (rise) begin
                viol_q   <= viol;
                ppage_o  <= ppage_d;
                offset_o <= laddr_i[OFF_W-1:0];
            end
        end
    end

    // Release the error flag only for a valid, clean access under a live strobe.
    assign prot_err_n_o = strobe_i && valid_o && !viol_q;
endmodule

// File: rtl/pxu_checker.sv
// Checker: timing properties of the translation unit, bound to the top.
// Assumes the synchronous active-low reset of the top module.
module pxu_checker
    import pxu_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               strobe_i,
    input logic [15:0]        laddr_i,
    input logic               ext_mode_i,
    input logic [PPAGE_W-1:0] ppage_o,
    input logic [OFF_W-1:0]   offset_o,
    input logic               valid_o,
    input logic               prot_err_n_o
);
    assert_err_low_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe_i |-> !prot_err_n_o);

    assert_valid_after_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(strobe_i) |=> valid_o);

    assert_valid_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(strobe_i) |-> !valid_o);

    assert_offset_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(strobe_i) |=> (offset_o == $past(laddr_i[OFF_W-1:0])));

    assert_no_ext_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(strobe_i) && !ext_mode_i) |=> (ppage_o[PPAGE_W-1 -: EXT_W] == '0));
endmodule

bind page_xlate_unit pxu_checker u_chk (
    .clk(clk), .rst_n(rst_n), .strobe_i(strobe_i), .laddr_i(laddr_i),
    .ext_mode_i(ext_mode_i), .ppage_o(ppage_o), .offset_o(offset_o),
    .valid_o(valid_o), .prot_err_n_o(prot_err_n_o)
);

// File: tb/tb_page_xlate_unit.sv
// Directed bench for the paged address translation unit.
module tb_page_xlate_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        strobe_i, opnd_i, rd_i, dma_ack_n_i, stat_we_i;
    logic        ext_mode_i, priv_i, preg_we_i;
    logic [15:0] laddr_i, preg_wdata_i;
    logic [3:0]  pin_as_i, pin_ps_i, stat_as_i, stat_ps_i;
    logic [8:0]  preg_idx_i;
    logic [10:0] ppage_o;
    logic [11:0] offset_o;
    logic        valid_o, prot_err_n_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    page_xlate_unit dut (
        .clk(clk), .rst_n(rst_n), .strobe_i(strobe_i), .laddr_i(laddr_i),
        .opnd_i(opnd_i), .rd_i(rd_i), .dma_ack_n_i(dma_ack_n_i),
        .pin_as_i(pin_as_i), .pin_ps_i(pin_ps_i), .stat_we_i(stat_we_i),
        .stat_as_i(stat_as_i), .stat_ps_i(stat_ps_i), .ext_mode_i(ext_mode_i),
        .priv_i(priv_i), .preg_we_i(preg_we_i), .preg_idx_i(preg_idx_i),
        .preg_wdata_i(preg_wdata_i), .ppage_o(ppage_o), .offset_o(offset_o),
        .valid_o(valid_o), .prot_err_n_o(prot_err_n_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_preg(input logic [8:0] idx, input logic [15:0] d, input logic pv);
        @(negedge clk);
        preg_we_i = 1'b1; preg_idx_i = idx; preg_wdata_i = d; priv_i = pv;
        @(negedge clk);
        preg_we_i = 1'b0; priv_i = 1'b0;
    endtask

    // Start an access; outputs are sampled one clock after the strobe rise.
    task automatic access(input logic [15:0] a, input logic op, input logic rd,
                          input logic [3:0] st, input logic [3:0] key);
        @(negedge clk);
        laddr_i = a; opnd_i = op; rd_i = rd; pin_as_i = st; pin_ps_i = key;
        strobe_i = 1'b1;
        @(negedge clk);
    endtask

    task automatic end_access();
        strobe_i = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R11 reset err", prot_err_n_o, 0);
        chk("R2 reset valid", valid_o, 0);
    endtask

    task automatic t_identity();
        dma_ack_n_i = 1'b1;
        access(16'h3ABC, 1, 1, 0, 0);
        chk("R1 identity page", ppage_o, 11'h003);
        chk("R2 offset", offset_o, 12'hABC);
        chk("R2 valid", valid_o, 1);
        chk("R5 open", prot_err_n_o, 1);
        end_access();
        chk("R11 idle err", prot_err_n_o, 0);
        chk("R2 valid clears", valid_o, 0);
    endtask

    task automatic t_status();
        @(negedge clk);
        stat_we_i = 1'b1; stat_as_i = 4'h5; stat_ps_i = 4'h7;
        @(negedge clk);
        stat_we_i = 1'b0;
        access(16'h7123, 0, 1, 4'hC, 4'h0);
        chk("R9 status bank", ppage_o, 11'h057);
        chk("R9 status key open", prot_err_n_o, 1);
        end_access();
    endtask

    task automatic t_dma();
        dma_ack_n_i = 1'b0;
        access(16'h2000, 1, 1, 4'h9, 4'h0);
        chk("R8 pin bank", ppage_o, 11'h092);
        end_access();
    endtask

    task automatic t_program();
        wr_preg({4'h2, 1'b1, 4'h4}, 16'h35C7, 1'b1);
        ext_mode_i = 1'b0;
        access(16'h4001, 1, 1, 4'h2, 4'h3);
        chk("R4 page no ext", ppage_o, 11'h0C7);
        chk("R5 key equals lock", prot_err_n_o, 1);
        end_access();
        ext_mode_i = 1'b1;
        access(16'h4001, 1, 1, 4'h2, 4'h0);
        chk("R4 page ext", ppage_o, 11'h5C7);
        chk("R5 key zero", prot_err_n_o, 1);
        end_access();
        ext_mode_i = 1'b0;
        access(16'h4001, 1, 1, 4'h2, 4'h4);
        chk("R5 key mismatch", prot_err_n_o, 0);
        chk("R5 valid on error", valid_o, 1);
        end_access();
        access(16'h4001, 0, 1, 4'h2, 4'h4);
        chk("R3 instr group untouched", ppage_o, 11'h024);
        chk("R5 lock F any key", prot_err_n_o, 1);
        end_access();
    endtask

    task automatic t_inhibit();
        wr_preg({4'h1, 1'b1, 4'h0}, 16'hF811, 1'b1);
        wr_preg({4'h1, 1'b0, 4'h0}, 16'hF822, 1'b1);
        access(16'h0000, 1, 1, 4'h1, 4'h6);
        chk("R6 operand read ok", prot_err_n_o, 1);
        chk("R3 operand group", ppage_o, 11'h011);
        end_access();
        access(16'h0000, 1, 0, 4'h1, 4'h6);
        chk("R6 operand write blocked", prot_err_n_o, 0);
        end_access();
        access(16'h0000, 0, 1, 4'h1, 4'h6);
        chk("R7 fetch blocked", prot_err_n_o, 0);
        chk("R3 instr group", ppage_o, 11'h022);
        end_access();
    endtask

    task automatic t_priv();
        wr_preg({4'h0, 1'b1, 4'h3}, 16'h0077, 1'b0);
        access(16'h3000, 1, 1, 4'h0, 4'h7);
        chk("R10 page kept", ppage_o, 11'h003);
        chk("R10 lock kept", prot_err_n_o, 1);
        end_access();
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; strobe_i = 1'b0; laddr_i = '0; opnd_i = 1'b1; rd_i = 1'b1;
        dma_ack_n_i = 1'b1; pin_as_i = '0; pin_ps_i = '0; stat_we_i = 1'b0;
        stat_as_i = '0; stat_ps_i = '0; ext_mode_i = 1'b0; priv_i = 1'b0;
        preg_we_i = 1'b0; preg_idx_i = '0; preg_wdata_i = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_identity();
        t_status();
        t_dma();
        t_program();
        t_inhibit();
        t_priv();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule